// File: doc/BRIEF.md
# Two-Operand Addressing Field Decoder

This block takes a 16-bit two-operand instruction word and works out how each operand is to be reached. For the source operand it reports one of seven operand kinds. The kinds are: register, indexed, indirect, indirect with autoincrement, immediate, absolute, and generated constant. It also reports the constant value when the kind is a generated constant, the autoincrement step, and whether an extra instruction word must be fetched. For the destination it reports register, indexed or absolute, and whether an extra word is needed. It also gives the total number of extra words the instruction needs.

The source mode field is only two bits wide, yet the block reaches seven modes and six short constants. It does this by giving special meaning to three registers. Register 0 is the program counter. Register 2 is the status register and reads as zero for address generation. Register 3 is a dedicated constant source. Register 1, the stack pointer, is decoded like any general register, which gives stack-relative access.

A fetch stage presents one word per cycle with a valid strobe. The decoded fields appear one clock later and hold until the next valid word arrives.

Top module: `opaddr_decoder`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, outValid is 0 and every decoded output is 0 until the first valid word is taken.
- R2: A word presented with inValid high is decoded onto the outputs at the next rising clock edge, and outValid rises there. When inValid is low, outValid is 0 after the next edge and all other outputs keep their previous values.
- R3: The word fields sit at these positions: source register [11:8], destination mode [7], byte flag [6] (1 means byte), source mode [5:4] and destination register [3:0]. Kind codes are register=0, indexed=1, indirect=2, autoincrement=3, immediate=4, absolute=5 and constant=6. For registers 1 and 4 to 15, source modes 00, 01, 10 and 11 give register, indexed, indirect and autoincrement.
- R4: With source register 0, mode 11 decodes as immediate, and mode 01 decodes as indexed. Both need one extra word. Modes 00 and 10 decode as register and indirect.
- R5: With source register 2, mode 01 decodes as absolute with one extra word, and mode 00 decodes as register.
- R6: Generated constants have kind 6, zero extra words, and a step of 0. Register 3 with modes 00, 01, 10 and 11 gives 0x0000, 0x0001, 0x0002 and 0xFFFF. Register 2 with mode 10 gives 0x0004 and with mode 11 gives 0x0008. For every other kind, srcConst is 0.
- R7: srcStep is 1 for a byte autoincrement and 2 for a word autoincrement. An immediate operand always steps by 2. Every other kind has a step of 0.
- R8: Destination mode 0 gives register with no extra word. Destination mode 1 gives indexed with one extra word, except that destination register 2 gives absolute. Indirect kinds never appear on the destination.
- R9: extraWords equals srcWords plus dstWords and never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Two-operand instruction word |
| outValid | output | 1 | Decoded fields updated this cycle |
| srcKind | output | 3 | Source operand kind code |
| srcConst | output | 16 | Generated constant value |
| srcStep | output | 2 | Source autoincrement step in bytes |
| srcWords | output | 1 | Source needs an extra word |
| dstKind | output | 3 | Destination operand kind code |
| dstWords | output | 1 | Destination needs an extra word |
| extraWords | output | 2 | Total extra words for the instruction |

## Verification
The hardest cases are the ones where a special register and a particular mode combine. Examples are register 3 with mode 11, which must give the all-ones constant rather than an autoincrement, and register 0 with mode 11 on a byte operation, which must still step by 2. A table walks every mode on each special register and on ordinary registers 1, 5 and 7, under both byte and word flags. It pairs these with destinations on register 2, register 3 and general registers, so the extra-word total reaches 0, 1 and 2. Directed steps then drop inValid while the word changes, to show that the outputs hold, and apply reset in the middle of the run.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    KIND_REG       = 3'd0,
    KIND_INDEXED   = 3'd1,
    KIND_INDIRECT  = 3'd2,
    KIND_AUTOINC   = 3'd3,
    KIND_IMMEDIATE = 3'd4,
    KIND_ABSOLUTE  = 3'd5,
    KIND_CONST     = 3'd6
  } opKind_e;

  // Strobes from the field control to the decode datapath
  typedef struct packed {
    logic       take;
    logic       srcIsPc;
    logic       srcIsSr;
    logic       srcIsCg;
    logic       dstIndexed;
    logic       dstIsSr;
    logic       byteOp;
    logic [1:0] srcMode;
  } decStrobes_t;

endpackage

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
  import opaddr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int REG_W   = 4,
  parameter int PC_IDX  = 0,
  parameter int SR_IDX  = 2,
  parameter int CG_IDX  = 3
) (
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output decStrobes_t        strobes
);
  // Field positions, fixed by the instruction format
  localparam int DST_REG_LSB  = 0;
  localparam int SRC_MODE_LSB = DST_REG_LSB + REG_W;
  localparam int BYTE_POS     = SRC_MODE_LSB + 2;
  localparam int DST_MODE_POS = BYTE_POS + 1;
  localparam int SRC_REG_LSB  = DST_MODE_POS + 1;

  logic [REG_W-1:0] srcReg;
  logic [REG_W-1:0] dstReg;

  always_comb begin
    srcReg = instrWord[SRC_REG_LSB +: REG_W];
    dstReg = instrWord[DST_REG_LSB +: REG_W];
    strobes.take       = inValid;
    strobes.srcIsPc    = (srcReg == REG_W'(PC_IDX));
    strobes.srcIsSr    = (srcReg == REG_W'(SR_IDX));
    strobes.srcIsCg    = (srcReg == REG_W'(CG_IDX));
    strobes.dstIndexed = instrWord[DST_MODE_POS];
    strobes.dstIsSr    = (dstReg == REG_W'(SR_IDX));
    strobes.byteOp     = instrWord[BYTE_POS];
    strobes.srcMode    = instrWord[SRC_MODE_LSB +: 2];
  end
endmodule

// File: rtl/opaddr_dpath.sv
module opaddr_dpath
  import opaddr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STEP_W    = 2,
  parameter int WORD_STEP = 2,
  parameter int BYTE_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobes_t       strobes,
  output logic              outValid,
  output opKind_e           srcKind,
  output logic [DATA_W-1:0] srcConst,
  output logic [STEP_W-1:0] srcStep,
  output logic              srcWords,
  output opKind_e           dstKind,
  output logic              dstWords,
  output logic [1:0]        extraWords
);
  localparam logic [DATA_W-1:0] CONST_FOUR  = DATA_W'(4);
  localparam logic [DATA_W-1:0] CONST_EIGHT = DATA_W'(8);

  opKind_e           nSrcKind;
  opKind_e           nDstKind;
  logic [DATA_W-1:0] nConst;
  logic [STEP_W-1:0] nStep;
  logic              nSrcWords;
  logic              nDstWords;

  // Source kind selection
  always_comb begin
    nSrcKind = KIND_REG;
    if (strobes.srcIsCg) begin
      nSrcKind = KIND_CONST;
    end else if (strobes.srcIsSr) begin
      unique case (strobes.srcMode)
        2'b00:   nSrcKind = KIND_REG;
        2'b01:   nSrcKind = KIND_ABSOLUTE;
        default: nSrcKind = KIND_CONST;
      endcase
    end else begin
      unique case (strobes.srcMode)
        2'b00:   nSrcKind = KIND_REG;
        2'b01:   nSrcKind = KIND_INDEXED;
        2'b10:   nSrcKind = KIND_INDIRECT;
        default: nSrcKind = strobes.srcIsPc ? KIND_IMMEDIATE : KIND_AUTOINC;
      endcase
    end
  end

  // Constant generator
  always_comb begin
    nConst = '0;
    if (strobes.srcIsCg) begin
      unique case (strobes.srcMode)
        2'b00:   nConst = '0;
        2'b01:   nConst = DATA_W'(1);
        2'b10:   nConst = DATA_W'(2);
        default: nConst = '1;
      endcase
    end else if (strobes.srcIsSr && strobes.srcMode[1]) begin
      nConst = strobes.srcMode[0] ? CONST_EIGHT : CONST_FOUR;
    end
  end

  // Step and extra-word generation
  always_comb begin
    nStep = '0;
    if (nSrcKind == KIND_IMMEDIATE)
      nStep = STEP_W'(WORD_STEP);
    else if (nSrcKind == KIND_AUTOINC)
      nStep = strobes.byteOp ? STEP_W'(BYTE_STEP) : STEP_W'(WORD_STEP);
    nSrcWords = (nSrcKind == KIND_INDEXED) || (nSrcKind == KIND_ABSOLUTE) ||
                (nSrcKind == KIND_IMMEDIATE);
    nDstWords = strobes.dstIndexed;
    if (!strobes.dstIndexed)
      nDstKind = KIND_REG;
    else if (strobes.dstIsSr)
      nDstKind = KIND_ABSOLUTE;
    else
      nDstKind = KIND_INDEXED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      srcKind    <= KIND_REG;
      srcConst   <= '0;
      srcStep    <= '0;
      srcWords   <= 1'b0;
      dstKind    <= KIND_REG;
      dstWords   <= 1'b0;
      extraWords <= 2'd0;
    end else begin
      outValid <= strobes.take;
      if (strobes.take) begin
        srcKind    <= nSrcKind;
        srcConst   <= nConst;
        srcStep    <= nStep;
        srcWords   <= nSrcWords;
        dstKind    <= nDstKind;
        dstWords   <= nDstWords;
        extraWords <= {1'b0, nSrcWords} + {1'b0, nDstWords};
      end
    end
  end

  AST_PC_AUTOINC_IMM: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && strobes.srcIsPc && strobes.srcMode == 2'b11)
      |=> (srcKind == KIND_IMMEDIATE && srcWords && srcStep == STEP_W'(WORD_STEP))); // R4
  AST_SR_INDEX_ABS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && strobes.srcIsSr && strobes.srcMode == 2'b01)
      |=> (srcKind == KIND_ABSOLUTE && srcWords)); // R5
  AST_CONST_NO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && srcKind == KIND_CONST) |-> (!srcWords && srcStep == '0)); // R6
  AST_STEP_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && srcKind != KIND_AUTOINC && srcKind != KIND_IMMEDIATE)
      |-> (srcStep == '0)); // R7
  AST_DST_NO_INDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (dstKind == KIND_REG || dstKind == KIND_INDEXED ||
                  dstKind == KIND_ABSOLUTE)); // R8
  AST_EXTRA_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (extraWords <= 2'd2)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> ($stable(srcKind) && $stable(srcConst) && $stable(dstKind) &&
                       !outValid)); // R2
endmodule

// File: rtl/opaddr_decoder.sv
module opaddr_decoder
  import opaddr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int REG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int STEP_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               outValid,
  output logic [2:0]         srcKind,
  output logic [DATA_W-1:0]  srcConst,
  output logic [STEP_W-1:0]  srcStep,
  output logic               srcWords,
  output logic [2:0]         dstKind,
  output logic               dstWords,
  output logic [1:0]         extraWords
);
  decStrobes_t strobes;
  opKind_e     srcKindE;
  opKind_e     dstKindE;

  opaddr_ctrl #(
    .INSTR_W(INSTR_W),
    .REG_W  (REG_W)
  ) u_ctrl (
    .inValid  (inValid),
    .instrWord(instrWord),
    .strobes  (strobes)
  );

  opaddr_dpath #(
    .DATA_W(DATA_W),
    .STEP_W(STEP_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .outValid  (outValid),
    .srcKind   (srcKindE),
    .srcConst  (srcConst),
    .srcStep   (srcStep),
    .srcWords  (srcWords),
    .dstKind   (dstKindE),
    .dstWords  (dstWords),
    .extraWords(extraWords)
  );

  assign srcKind = srcKindE;
  assign dstKind = dstKindE;
endmodule

// File: tb/tb_opaddr_decoder.sv
module tb_opaddr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        outValid;
  logic [2:0]  srcKind;
  logic [15:0] srcConst;
  logic [1:0]  srcStep;
  logic        srcWords;
  logic [2:0]  dstKind;
  logic        dstWords;
  logic [1:0]  extraWords;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  opaddr_decoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .outValid(outValid), .srcKind(srcKind), .srcConst(srcConst),
    .srcStep(srcStep), .srcWords(srcWords), .dstKind(dstKind),
    .dstWords(dstWords), .extraWords(extraWords)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] instr;
    logic [2:0]  sKind;
    logic [15:0] sConst;
    logic [1:0]  sStep;
    logic [2:0]  dKind;
    logic [1:0]  extra;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 16'h4506, 3'd0, 16'h0000, 2'd0, 3'd0, 2'd0}, // R3 reg / reg
    '{8'd3, 16'h4596, 3'd1, 16'h0000, 2'd0, 3'd1, 2'd2}, // R3 indexed / indexed
    '{8'd3, 16'h4124, 3'd2, 16'h0000, 2'd0, 3'd0, 2'd0}, // R3 stack pointer indirect
    '{8'd7, 16'h4738, 3'd3, 16'h0000, 2'd2, 3'd0, 2'd0}, // R7 word autoinc
    '{8'd7, 16'h4778, 3'd3, 16'h0000, 2'd1, 3'd0, 2'd0}, // R7 byte autoinc
    '{8'd4, 16'h40F9, 3'd4, 16'h0000, 2'd2, 3'd1, 2'd2}, // R4 byte immediate
    '{8'd4, 16'h4014, 3'd1, 16'h0000, 2'd0, 3'd0, 2'd1}, // R4 pc indexed
    '{8'd4, 16'h4004, 3'd0, 16'h0000, 2'd0, 3'd0, 2'd0}, // R4 pc register
    '{8'd5, 16'h4292, 3'd5, 16'h0000, 2'd0, 3'd5, 2'd2}, // R5 absolute both
    '{8'd6, 16'h4225, 3'd6, 16'h0004, 2'd0, 3'd0, 2'd0}, // R6 const 4
    '{8'd6, 16'h4235, 3'd6, 16'h0008, 2'd0, 3'd0, 2'd0}, // R6 const 8
    '{8'd6, 16'h4305, 3'd6, 16'h0000, 2'd0, 3'd0, 2'd0}, // R6 const 0
    '{8'd6, 16'h4397, 3'd6, 16'h0001, 2'd0, 3'd1, 2'd1}, // R6 const 1
    '{8'd6, 16'h4325, 3'd6, 16'h0002, 2'd0, 3'd0, 2'd0}, // R6 const 2
    '{8'd6, 16'h4375, 3'd6, 16'hFFFF, 2'd0, 3'd0, 2'd0}, // R6 const -1 byte
    '{8'd8, 16'h4283, 3'd0, 16'h0000, 2'd0, 3'd1, 2'd1}, // R8 dst r3 indexed, R5 sr reg
    '{8'd4, 16'h4024, 3'd2, 16'h0000, 2'd0, 3'd0, 2'd0}, // R4 pc indirect
    '{8'd9, 16'h4191, 3'd1, 16'h0000, 2'd0, 3'd1, 2'd2}  // R9 sum of two
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAllZero(input string req);
    check(req, "outValid", 32'(outValid), 0);
    check(req, "decoded", {srcKind, srcConst, srcStep, srcWords, dstKind,
                           dstWords, extraWords}, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAllZero("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAllZero("R1");

    for (int i = 0; i < NV; i++) begin
      string rq;
      logic eS, eD;
      rq = $sformatf("R%0d", VECS[i].req);
      instrWord = VECS[i].instr;
      inValid = 1'b1;
      @(negedge clk);
      eS = (VECS[i].sKind == 3'd1) || (VECS[i].sKind == 3'd4) || (VECS[i].sKind == 3'd5);
      eD = (VECS[i].dKind != 3'd0);
      check("R2", "outValid", 32'(outValid), 1);
      check(rq, "srcKind", 32'(srcKind), 32'(VECS[i].sKind));
      check(rq, "srcConst", 32'(srcConst), 32'(VECS[i].sConst));
      check(rq, "srcStep", 32'(srcStep), 32'(VECS[i].sStep));
      check(rq, "dstKind", 32'(dstKind), 32'(VECS[i].dKind));
      check("R9", "srcWords", 32'(srcWords), 32'(eS));
      check("R9", "dstWords", 32'(dstWords), 32'(eD));
      check("R9", "extraWords", 32'(extraWords), 32'(VECS[i].extra));
    end

    // R2: idle cycle with a changed word must hold the last decode
    instrWord = 16'h4375;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    instrWord = 16'h4596;
    @(negedge clk);
    check("R2", "outValid idle", 32'(outValid), 0);
    check("R2", "srcKind hold", 32'(srcKind), 6);
    check("R2", "srcConst hold", 32'(srcConst), 32'hFFFF);
    check("R2", "dstKind hold", 32'(dstKind), 0);
    check("R2", "extra hold", 32'(extraWords), 0);

    // R1: reset in the middle clears the decode
    inValid = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkAllZero("R1");
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    checkAllZero("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule